// File: doc/BRIEF.md
# Oversampled Serial Receiver with Frame Acceptance Filter

This block receives asynchronous serial frames on a single line. A one-cycle enable, `tick16`, pulses sixteen times per bit period. All receive work happens on the clock cycles where that enable is high. While the receiver is idle, a high-to-low change of the line between two ticks marks a start bit. That tick resets the bit-phase counter so that the counter's wrap points fall on the incoming bit boundaries. Three samples taken in the middle of each bit are combined by a two-of-three vote. A start bit that votes high is treated as noise, and the receiver goes back to idle.

The frame is collected in a shift register that is preset to all ones. Each voted bit enters at a fixed position and moves toward bit 0. Once the zero start bit reaches bit 0, the next bit is the last one of the frame. On that last bit the block decides whether to deliver the frame. Delivery writes the data byte and an extra bit to holding registers and raises a sticky receive flag. The extra bit is the stop bit in the 8-data-bit format and the ninth data bit in the 9-data-bit format. A frame is discarded without trace if the flag is still set, or if address filtering is on and the extra bit is 0. In every case the receiver returns to watching for a falling edge right after the last bit.

Top module: `uart_sentinel_rx`

## Requirements
- R1: After a synchronous active-low reset, `rx_flag`, `rx_extra` and `rx_byte` are 0 and the receiver is idle. The line's previous sample is taken as low, so the line must be seen high on one tick before any start can be found.
- R2: A reception starts only on a tick where the receiver is idle, the line was high on the previous tick and is low on this tick. A line held low never starts a reception.
- R3: The tick of the start edge is phase 0 of the start bit, and every bit lasts 16 ticks. The bit value is the majority of the line samples at phases 7, 8 and 9. A single disagreeing sample, or any line activity at other phases, does not change the value.
- R4: If the start bit votes 1, the reception is abandoned with no effect on the outputs. The receiver is idle again and accepts a following valid frame.
- R5: With `nine_bit` = 0, a frame is a 0 start bit, 8 data bits LSB first and a stop bit. On delivery `rx_byte` holds the data, `rx_extra` holds the stop bit (whatever its value) and `rx_flag` becomes 1.
- R6: With `nine_bit` = 1, a frame is a 0 start bit, 8 data bits LSB first, a ninth data bit and a stop bit. On delivery `rx_extra` holds the ninth bit, and the stop bit's value has no effect.
- R7: A frame that completes while `rx_flag` is 1 is dropped, and `rx_byte` and `rx_extra` keep their values.
- R8: With `mp_enable` = 1, a frame is delivered only when its extra bit (the stop bit or the ninth bit, as in R5 and R6) is 1. Otherwise it is dropped. With `mp_enable` = 0 the extra bit's value does not matter.
- R9: `rx_flag` stays 1 until `rflag_clr` is 1 on a clock edge. If a delivery and `rflag_clr` fall on the same edge, the delivery wins and the flag ends at 1.
- R10: Outputs change only on the tick that decides the frame's last bit, and only when the frame is delivered. Delivered or dropped, the receiver is then idle, so a start edge directly after the stop bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| nine_bit | input | 1 | Frame format: 0 = 8 data bits, 1 = 9 data bits |
| mp_enable | input | 1 | Deliver only frames whose extra bit is 1 |
| rflag_clr | input | 1 | Clears the receive flag |
| rx_byte | output | DATA_W | Last delivered data byte |
| rx_extra | output | 1 | Last delivered stop bit or ninth bit |
| rx_flag | output | 1 | Sticky frame-delivered flag |

## Verification
On every cycle the bound checks confirm four things. A set flag freezes the byte and the extra bit. The flag holds until it is cleared, and a clear on a set flag takes effect. Every delivery lines up with a tick and obeys the address filter. The bench scenarios cover what needs a whole waveform on the line: the vote at phases 7 to 9 against deliberate glitches, rejected start bits, a low line from reset that must not start a frame, the bit order and placement of the extra bit in both formats, and back-to-back frames where a dropped frame is directly followed by an accepted one.

// File: rtl/sentinel_rx_pkg.sv
// Shared helpers for the oversampled serial receiver.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package sentinel_rx_pkg;

    // Two-of-three vote used for mid-bit noise rejection.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_phase_ctr.sv
// Bit-phase counter. Counts sample ticks within a bit time while a
// reception runs; a restart makes the next tick phase 1 (the restart
// tick itself is phase 0). Assumes restart and run are never both set.
module rx_phase_ctr #(
    parameter int OVERSAMPLE = 16,
    parameter int PH_W       = $clog2(OVERSAMPLE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            restart,
    input  logic            run,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    // Advance the phase on each tick, wrapping at the end of a bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick && restart) begin
            phase <= PH_ONE;
        end else if (tick && run) begin
            phase <= (phase == PH_LAST) ? '0 : phase + PH_ONE;
        end
    end
endmodule

// File: rtl/rx_bit_voter.sv
// Mid-bit sampler. Keeps the line value at the first two vote phases
// and, on the tick of the third, presents the majority value with a
// one-cycle strobe. Assumes phase is valid whenever run is high.
module rx_bit_voter
    import sentinel_rx_pkg::*;
#(
    parameter int PH_W       = 4,
    parameter int VOTE_FIRST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic [PH_W-1:0] phase,
    input  logic            rxd,
    output logic            bit_strobe,
    output logic            bit_val
);
    localparam logic [PH_W-1:0] PH_A = PH_W'(VOTE_FIRST);
    localparam logic [PH_W-1:0] PH_B = PH_W'(VOTE_FIRST + 1);
    localparam logic [PH_W-1:0] PH_C = PH_W'(VOTE_FIRST + 2);

    logic samp_a, samp_b;

    // Store the first two votes of the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick && run) begin
            if (phase == PH_A) samp_a <= rxd;
            if (phase == PH_B) samp_b <= rxd;
        end
    end

    // Decide the bit on the third vote tick.
    always_comb begin
        bit_strobe = tick && run && (phase == PH_C);
        bit_val    = vote3(samp_a, samp_b, rxd);
    end
endmodule

// File: rtl/rx_frame_ctl.sv
// Frame assembler. Finds the start edge, holds the busy state and the
// all-ones preset shift register; a voted bit enters at the top of the
// active width and moves down. When the zero start bit sits in bit 0,
// the next voted bit is the last of the frame. Assumes nine_bit is
// stable for the length of a frame.
module rx_frame_ctl #(
    parameter int DATA_W = 8,
    parameter int SR_W   = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              nine_bit,
    input  logic              bit_strobe,
    input  logic              bit_val,
    output logic              restart,
    output logic              run,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_extra
);
    logic            prev_rxd;
    logic            busy;
    logic [SR_W-1:0] sr;
    logic [SR_W-1:0] sr_shifted;
    logic            first_bit;
    logic            last_bit;

    // Line history for edge detection, taken once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_rxd <= 1'b0;
        else if (tick) prev_rxd <= rxd;
    end

    // Decode start edge, first/last bit and the next shift value.
    always_comb begin
        restart    = tick && !busy && prev_rxd && !rxd;
        run        = busy;
        first_bit  = &sr;
        last_bit   = !sr[0];
        sr_shifted = nine_bit ? {bit_val, sr[SR_W-1:1]}
                              : {1'b1, bit_val, sr[SR_W-2:1]};
        frame_done  = bit_strobe && last_bit;
        frame_data  = sr[DATA_W:1];
        frame_extra = nine_bit ? sr[SR_W-1] : bit_val;
    end

    // Busy state: set by a start edge, cleared by a false start or frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (restart) begin
            busy <= 1'b1;
        end else if (bit_strobe && ((first_bit && bit_val) || last_bit)) begin
            busy <= 1'b0;
        end
    end

    // Shift register: preset on a start edge, shifted on each voted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '1;
        end else if (restart) begin
            sr <= '1;
        end else if (bit_strobe && !last_bit && !(first_bit && bit_val)) begin
            sr <= sr_shifted;
        end
    end
endmodule

// File: rtl/rx_hold_regs.sv
// Holding registers and sticky flag. A finished frame is written only
// when the flag is clear and the address filter passes it; a clear
// request loses against a write on the same edge.
module rx_hold_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_extra,
    input  logic              mp_enable,
    input  logic              rflag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_extra,
    output logic              rx_flag
);
    logic accept;

    // Acceptance rule for a finished frame.
    always_comb begin
        accept = frame_done && !rx_flag && (!mp_enable || frame_extra);
    end

    // Capture an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_extra <= 1'b0;
        end else if (accept) begin
            rx_byte  <= frame_data;
            rx_extra <= frame_extra;
        end
    end

    // Sticky flag: set on acceptance, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_flag <= 1'b0;
        else if (accept)    rx_flag <= 1'b1;
        else if (rflag_clr) rx_flag <= 1'b0;
    end
endmodule

// File: rtl/uart_sentinel_rx.sv
// Top level of the oversampled serial receiver. Wires the phase
// counter, bit voter, frame assembler and holding registers. Assumes
// tick16 is a one-cycle enable at 16x the bit rate and rxd is already
// synchronized to clk.
module uart_sentinel_rx #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16,
    parameter int VOTE_FIRST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              nine_bit,
    input  logic              mp_enable,
    input  logic              rflag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_extra,
    output logic              rx_flag
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam int SR_W = DATA_W + 2;

    logic              restart, run;
    logic [PH_W-1:0]   phase;
    logic              bit_strobe, bit_val;
    logic              frame_done, frame_extra;
    logic [DATA_W-1:0] frame_data;

    rx_phase_ctr #(.OVERSAMPLE(OVERSAMPLE), .PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .restart(restart), .run(run), .phase(phase)
    );

    rx_bit_voter #(.PH_W(PH_W), .VOTE_FIRST(VOTE_FIRST)) u_voter (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .run(run), .phase(phase),
        .rxd(rxd), .bit_strobe(bit_strobe), .bit_val(bit_val)
    );

    rx_frame_ctl #(.DATA_W(DATA_W), .SR_W(SR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .nine_bit(nine_bit), .bit_strobe(bit_strobe), .bit_val(bit_val),
        .restart(restart), .run(run), .frame_done(frame_done),
        .frame_data(frame_data), .frame_extra(frame_extra)
    );

    rx_hold_regs #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .frame_data(frame_data), .frame_extra(frame_extra),
        .mp_enable(mp_enable), .rflag_clr(rflag_clr),
        .rx_byte(rx_byte), .rx_extra(rx_extra), .rx_flag(rx_flag)
    );
endmodule

// File: rtl/rx_sentinel_checker.sv
// Port-level temporal checks for the serial receiver, bound to the top.
module rx_sentinel_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              mp_enable,
    input logic              rflag_clr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_extra,
    input logic              rx_flag
);
    // R7: a set flag blocks any write to the holding registers.
    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |=> ($stable(rx_byte) && $stable(rx_extra)));

    // R9: the flag stays set without a clear request.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !rflag_clr) |=> rx_flag);

    // R9: a clear on a set flag takes effect on the next edge.
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && rflag_clr) |=> !rx_flag);

    // R8: with filtering on, only frames with extra bit 1 are delivered.
    p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> (!$past(mp_enable) || rx_extra));

    // R10: a delivery happens only on a sample tick.
    p_rise_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(tick16));

    // R10: the data byte changes only together with a delivery.
    p_byte_with_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> $rose(rx_flag));
endmodule

bind uart_sentinel_rx rx_sentinel_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .mp_enable(mp_enable),
    .rflag_clr(rflag_clr), .rx_byte(rx_byte), .rx_extra(rx_extra),
    .rx_flag(rx_flag)
);

// File: tb/uart_sentinel_rx_test.sv
module uart_sentinel_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b0;
    logic       nine_bit = 1'b0;
    logic       mp_enable = 1'b0;
    logic       rflag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_extra;
    logic       rx_flag;

    int checks = 0;
    int errors = 0;

    uart_sentinel_rx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .nine_bit(nine_bit), .mp_enable(mp_enable), .rflag_clr(rflag_clr),
        .rx_byte(rx_byte), .rx_extra(rx_extra), .rx_flag(rx_flag)
    );

    always #4 clk = ~clk;   // 125 MHz

    // 16x enable: one clock high in every four.
    initial begin
        forever begin
            repeat (3) begin @(negedge clk); tick16 = 1'b0; end
            @(negedge clk); tick16 = 1'b1;
        end
    end

    // Fields: nine, mp, clr, data[8], ninth, stop, exp_flag, exp_byte[8], exp_extra
    localparam int NVEC = 9;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,8'hA5,1'b0,1'b1, 1'b1,8'hA5,1'b1},
        {1'b0,1'b0,1'b0,8'h3C,1'b0,1'b1, 1'b1,8'hA5,1'b1},
        {1'b0,1'b0,1'b1,8'h3C,1'b0,1'b0, 1'b1,8'h3C,1'b0},
        {1'b1,1'b0,1'b1,8'h81,1'b1,1'b1, 1'b1,8'h81,1'b1},
        {1'b1,1'b0,1'b1,8'h7E,1'b0,1'b1, 1'b1,8'h7E,1'b0},
        {1'b1,1'b1,1'b1,8'h55,1'b0,1'b1, 1'b0,8'h7E,1'b0},
        {1'b1,1'b1,1'b0,8'h5A,1'b1,1'b0, 1'b1,8'h5A,1'b1},
        {1'b0,1'b1,1'b1,8'hC3,1'b0,1'b0, 1'b0,8'h5A,1'b1},
        {1'b0,1'b1,1'b0,8'h0F,1'b0,1'b1, 1'b1,8'h0F,1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic ef, input logic [7:0] eb, input logic ee);
        check({tag, " flag"},  {7'd0, rx_flag},  {7'd0, ef});
        check({tag, " byte"},  rx_byte, eb);
        check({tag, " extra"}, {7'd0, rx_extra}, {7'd0, ee});
    endtask

    // Wait for the next clock edge that carries a tick, then step off it.
    task automatic wait_tick();
        do @(posedge clk); while (tick16 !== 1'b1);
        #1;
    endtask

    task automatic pulse_clear();
        @(negedge clk); rflag_clr = 1'b1;
        @(negedge clk); rflag_clr = 1'b0;
    endtask

    // One bit time: slot j is seen by the tick of phase j; mask flips slots.
    task automatic send_bit(input logic v, input logic [15:0] mask, input logic clr9);
        for (int j = 0; j < 16; j++) begin
            rxd = v ^ mask[j];
            if (j == 9) rflag_clr = clr9;
            wait_tick();
            rflag_clr = 1'b0;
        end
    endtask

    task automatic send_frame(input logic nine, input logic [7:0] d, input logic ninth,
                              input logic stop, input logic [15:0] mask,
                              input logic clr9, input int idle_n);
        nine_bit = nine;
        send_bit(1'b0, mask, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i], mask, 1'b0);
        if (nine) send_bit(ninth, mask, 1'b0);
        send_bit(stop, mask, clr9);
        rxd = 1'b1;
        repeat (idle_n) wait_tick();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state, with the line held low from the start.
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset", 1'b0, 8'h00, 1'b0);

        // R2: a line low since reset never starts a frame.
        repeat (200) wait_tick();
        @(negedge clk);
        check_out("R2 held low", 1'b0, 8'h00, 1'b0);
        rxd = 1'b1;
        repeat (4) wait_tick();

        // R5/R6/R7/R8: table of frames.
        for (int k = 0; k < NVEC; k++) begin
            logic [22:0] v;
            v = VEC[k];
            mp_enable = v[21];
            if (v[20]) pulse_clear();
            wait_tick();
            send_frame(v[22], v[19:12], v[11], v[10], 16'h0000, 1'b0, 3);
            @(negedge clk);
            check_out($sformatf("R5/R6/R7/R8 vector %0d", k), v[9], v[8:1], v[0]);
        end

        // R9: the flag holds while idle and clears only on request.
        repeat (50) wait_tick();
        @(negedge clk);
        check_out("R9 sticky", 1'b1, 8'h0F, 1'b1);
        pulse_clear();
        @(negedge clk);
        check_out("R9 cleared", 1'b0, 8'h0F, 1'b1);

        // R9: a clear on the delivery edge loses to the delivery.
        mp_enable = 1'b0;
        wait_tick();
        send_frame(1'b0, 8'h66, 1'b0, 1'b1, 16'h0000, 1'b1, 2);
        @(negedge clk);
        check_out("R9 load beats clear", 1'b1, 8'h66, 1'b1);

        // R3: one wrong vote sample, and noise outside phases 7..9.
        pulse_clear();
        wait_tick();
        send_frame(1'b0, 8'h4B, 1'b0, 1'b1, 16'h0080, 1'b0, 2);
        @(negedge clk);
        check_out("R3 phase7 glitch", 1'b1, 8'h4B, 1'b1);
        pulse_clear();
        wait_tick();
        send_frame(1'b0, 8'hD2, 1'b0, 1'b1, 16'h0200, 1'b0, 2);
        @(negedge clk);
        check_out("R3 phase9 glitch", 1'b1, 8'hD2, 1'b1);
        pulse_clear();
        wait_tick();
        send_frame(1'b0, 8'h39, 1'b0, 1'b1, 16'hFC7E, 1'b0, 2);
        @(negedge clk);
        check_out("R3 off-phase noise", 1'b1, 8'h39, 1'b1);

        // R4: false starts are abandoned, then a real frame follows.
        pulse_clear();
        wait_tick();
        send_bit(1'b0, 16'hFF80, 1'b0);
        rxd = 1'b1;
        repeat (200) wait_tick();
        @(negedge clk);
        check_out("R4 short low pulse", 1'b0, 8'h39, 1'b1);
        send_bit(1'b1, 16'h0101, 1'b0);
        repeat (200) wait_tick();
        @(negedge clk);
        check_out("R4 single low vote", 1'b0, 8'h39, 1'b1);
        send_frame(1'b0, 8'h96, 1'b0, 1'b1, 16'h0000, 1'b0, 2);
        @(negedge clk);
        check_out("R4 frame after false start", 1'b1, 8'h96, 1'b1);

        // R10: a dropped frame is followed at once by an accepted one.
        pulse_clear();
        mp_enable = 1'b1;
        wait_tick();
        send_frame(1'b1, 8'h11, 1'b0, 1'b1, 16'h0000, 1'b0, 0);
        send_frame(1'b1, 8'h22, 1'b1, 1'b1, 16'h0000, 1'b0, 2);
        @(negedge clk);
        check_out("R10 back to back", 1'b1, 8'h22, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule